// File: doc/BRIEF.md
# Sub-word load/store alignment unit

This block sits between a processor's load/store path and a data memory that is one word wide. On a load it takes the whole memory word, the low address bits and the access width. It picks out the addressed byte or halfword and widens it to a full register value, filling the upper bits with either copies of the top bit or zeros. On a store it moves the source operand onto the addressed byte lanes of the write word. It also drives a per-lane write mask, so the memory changes only the bytes that the access covers.

The unit is purely combinational. An access that the memory cannot perform in one word is never carried out. A halfword at an odd address, a word that is not word-aligned, or a reserved width code raises a misalignment flag. Surrounding logic can turn that flag into a trap and emulate the access in software. Such an access writes nothing and returns a zero load value.

Encodings: `acc_kind` 00 = idle, 01 = load, 10 = store, 11 = idle. `acc_size` 00 = byte, 01 = halfword, 10 = word, 11 = reserved. `acc_zext` = 1 selects zero-extension and 0 selects sign-extension. Byte lane k of a word is bits 8k+7 down to 8k (little-endian).

Top module: `sw_align_unit`

## Requirements
- R1: Lanes are little-endian. For a byte load at offset k (`addr_lo` = k), the result comes from `mem_rdata` bits 8k+7:8k.
- R2: A legal byte load places the selected byte in `ld_value[7:0]`. Bits 31:8 are zero when `acc_zext`=1 and copies of the byte's bit 7 when `acc_zext`=0.
- R3: A legal halfword load takes bits 15:0 at offset 0 and bits 31:16 at offset 2. Bits 31:16 of the result are zero when `acc_zext`=1 and copies of the halfword's bit 15 when `acc_zext`=0.
- R4: A legal word load returns `mem_rdata` unchanged.
- R5: A legal byte store puts `st_src[7:0]` on lane `addr_lo` and sets only mask bit `addr_lo`. All other lanes of `mem_wdata` are zero.
- R6: A legal halfword store puts `st_src[15:0]` on bits 15:0 with mask 4'b0011 at offset 0, or on bits 31:16 with mask 4'b1100 at offset 2. The other lanes are zero.
- R7: A legal word store drives `mem_wdata` = `st_src` and mask 4'b1111.
- R8: For a load or store, `misaligned` is 1 exactly when the width is halfword with `addr_lo[0]`=1, or word with `addr_lo`≠0, or the reserved width code.
- R9: A misaligned access drives mask 0, `mem_wdata` 0 and `ld_value` 0.
- R10: With `acc_kind` idle (00 or 11), `misaligned` is 0 and the mask, `mem_wdata` and `ld_value` are all zero.
- R11: A load never sets any mask bit or drives data onto `mem_wdata`. A store always returns `ld_value` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Access kind: 00 idle, 01 load, 10 store, 11 idle |
| acc_size | input | 2 | Width: 00 byte, 01 halfword, 10 word, 11 reserved |
| acc_zext | input | 1 | 1 = zero-extend loads, 0 = sign-extend |
| addr_lo | input | 2 | Low address bits, byte offset in the word |
| mem_rdata | input | 32 | Full word read from memory |
| st_src | input | 32 | Store operand, right-aligned |
| ld_value | output | 32 | Extended load result |
| mem_wdata | output | 32 | Lane-steered write word |
| mem_wmask | output | 4 | Per-lane write enable, bit k = lane k |
| misaligned | output | 1 | Access cannot be done in one aligned word |

## Verification
The bench sweeps every kind, width, extension flag and offset against read words that put set and clear top bits in each lane. This catches a sign fill taken from the wrong bit, which would smear bit 7 of lane 0 over the result when a higher lane was addressed. Directed loads of a word with distinct byte values pin the lane order, so swapped lanes would return the mirror byte. The odd-offset halfword, unaligned word and reserved width cases check that a misaligned store leaves the mask zero. A design that got this wrong would corrupt memory on a trapped access. The idle code 11 is included so that decoding it as a store would show up as a stray write.

// File: rtl/sw_align_pkg.sv
// Shared encodings for the sub-word alignment unit.
// Assumes a two-bit kind and two-bit width field from the load/store decoder.
package sw_align_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_IDLE2 = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/sw_align_check.sv
// Decodes the access kind and judges alignment of the offset for the width.
// Assumes a halfword spans two lanes and a word spans all lanes.
module sw_align_check
    import sw_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [1:0]       kind,
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             do_load,
    output logic             do_store,
    output logic             bad_align
);
    logic active;
    logic bad_width;

    // Classify the width/offset pair and qualify it with the access kind.
    always_comb begin
        active = (acc_kind_e'(kind) == ACC_LOAD) || (acc_kind_e'(kind) == ACC_STORE);
        case (acc_size_e'(size))
            SZ_BYTE: bad_width = 1'b0;
            SZ_HALF: bad_width = off[0];
            SZ_WORD: bad_width = (off != '0);
            default: bad_width = 1'b1;
        endcase
        bad_align = active && bad_width;
        do_load   = (acc_kind_e'(kind) == ACC_LOAD)  && !bad_width;
        do_store  = (acc_kind_e'(kind) == ACC_STORE) && !bad_width;
    end

    // Idle codes never qualify and never flag (R10).
    always_comb begin
        if (!active) begin
            p_idle_quiet_r10: assert (!bad_align && !do_load && !do_store)
                else $error("idle access produced activity");
        end
    end
endmodule

// File: rtl/sw_load_extract.sv
// Picks the addressed byte or halfword from the read word and widens it.
// Assumes the halfword offset is even whenever the load is qualified.
module sw_load_extract
    import sw_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int HALF_W = 2 * LANE_W,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic              zext,
    input  logic              en,
    output logic [DATA_W-1:0] ldata
);
    logic [LANE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    logic              fill;

    // Select the lane slices addressed by the offset.
    always_comb begin
        byte_sel = rdata[int'(off) * LANE_W +: LANE_W];
        half_sel = rdata[int'(off[OFF_W-1:1]) * HALF_W +: HALF_W];
    end

    // Widen the selected slice with sign or zero fill.
    always_comb begin
        fill  = 1'b0;
        ldata = '0;
        if (en) begin
            case (acc_size_e'(size))
                SZ_BYTE: begin
                    fill  = !zext && byte_sel[LANE_W-1];
                    ldata = {{(DATA_W-LANE_W){fill}}, byte_sel};
                end
                SZ_HALF: begin
                    fill  = !zext && half_sel[HALF_W-1];
                    ldata = {{(DATA_W-HALF_W){fill}}, half_sel};
                end
                SZ_WORD: ldata = rdata;
                default: ldata = '0;
            endcase
        end
    end

    // Extension fills the upper bits from the right source (R2, R3).
    always_comb begin
        if (en && acc_size_e'(size) == SZ_BYTE) begin
            p_byte_fill_r2: assert (ldata[DATA_W-1:LANE_W] ==
                                    {(DATA_W-LANE_W){!zext && ldata[LANE_W-1]}})
                else $error("byte load upper fill wrong");
        end
        if (en && acc_size_e'(size) == SZ_HALF) begin
            p_half_fill_r3: assert (ldata[DATA_W-1:HALF_W] ==
                                    {(DATA_W-HALF_W){!zext && ldata[HALF_W-1]}})
                else $error("halfword load upper fill wrong");
        end
    end
endmodule

// File: rtl/sw_store_steer.sv
// Places the store operand onto the byte lanes of the write word and builds the mask.
// Assumes the operand is right-aligned and the offset is legal when en is high.
module sw_store_steer
    import sw_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic              en,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wmask
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic              hit;
        logic [LANE_W-1:0] src_lane;

        // Decide whether this lane is covered and which operand slice feeds it.
        always_comb begin
            case (acc_size_e'(size))
                SZ_BYTE: begin
                    hit      = (int'(off) == l);
                    src_lane = src[LANE_W-1:0];
                end
                SZ_HALF: begin
                    hit      = ((int'(off) / 2) == (l / 2));
                    src_lane = src[(l % 2) * LANE_W +: LANE_W];
                end
                SZ_WORD: begin
                    hit      = 1'b1;
                    src_lane = src[l * LANE_W +: LANE_W];
                end
                default: begin
                    hit      = 1'b0;
                    src_lane = '0;
                end
            endcase
        end

        assign wmask[l]                      = en && hit;
        assign wdata[l*LANE_W +: LANE_W]     = (en && hit) ? src_lane : '0;
    end

    // Mask population matches the width of a qualified store (R5, R6, R7).
    always_comb begin
        if (en && acc_size_e'(size) == SZ_BYTE) begin
            p_byte_onehot_r5: assert ($onehot(wmask))
                else $error("byte store mask not one-hot");
        end
        if (en && acc_size_e'(size) == SZ_HALF) begin
            p_half_pair_r6: assert ($countones(wmask) == 2)
                else $error("halfword store mask not two lanes");
        end
        if (en && acc_size_e'(size) == SZ_WORD) begin
            p_word_full_r7: assert (&wmask)
                else $error("word store mask not full");
        end
    end
endmodule

// File: rtl/sw_align_unit.sv
// Top of the sub-word alignment unit: load widening, store lane steering,
// per-lane write mask and misalignment flag. Purely combinational, so it has
// no clock or reset; the caller registers around it as its pipeline needs.
module sw_align_unit
    import sw_align_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size,
    input  logic              acc_zext,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] st_src,
    output logic [DATA_W-1:0] ld_value,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_wmask,
    output logic              misaligned
);
    logic do_load;
    logic do_store;

    sw_align_check #(.OFF_W(OFF_W)) u_check (
        .kind      (acc_kind),
        .size      (acc_size),
        .off       (addr_lo),
        .do_load   (do_load),
        .do_store  (do_store),
        .bad_align (misaligned)
    );

    sw_load_extract #(.LANE_W(LANE_W), .LANES(LANES)) u_load (
        .rdata (mem_rdata),
        .off   (addr_lo),
        .size  (acc_size),
        .zext  (acc_zext),
        .en    (do_load),
        .ldata (ld_value)
    );

    sw_store_steer #(.LANE_W(LANE_W), .LANES(LANES)) u_store (
        .src   (st_src),
        .off   (addr_lo),
        .size  (acc_size),
        .en    (do_store),
        .wdata (mem_wdata),
        .wmask (mem_wmask)
    );

    // Guard memory against illegal and non-store accesses (R9, R11).
    always_comb begin
        if (misaligned) begin
            p_mis_nowrite_r9: assert (mem_wmask == '0 && mem_wdata == '0 && ld_value == '0)
                else $error("misaligned access had an effect");
        end
        if (acc_kind_e'(acc_kind) == ACC_LOAD) begin
            p_load_nowrite_r11: assert (mem_wmask == '0)
                else $error("load asserted a write lane");
        end
        if (acc_kind_e'(acc_kind) == ACC_STORE) begin
            p_store_noload_r11: assert (ld_value == '0)
                else $error("store returned a load value");
        end
    end
endmodule

// File: tb/sw_align_unit_bench.sv
module sw_align_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [1:0]  acc_size = 2'b00;
    logic        acc_zext = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] mem_rdata = '0;
    logic [31:0] st_src = '0;
    logic [31:0] ld_value;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wmask;
    logic        misaligned;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    sw_align_unit u_sw_align_unit (
        .acc_kind   (acc_kind),
        .acc_size   (acc_size),
        .acc_zext   (acc_zext),
        .addr_lo    (addr_lo),
        .mem_rdata  (mem_rdata),
        .st_src     (st_src),
        .ld_value   (ld_value),
        .mem_wdata  (mem_wdata),
        .mem_wmask  (mem_wmask),
        .misaligned (misaligned)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input int k, input int s, input int z, input int o,
                         input logic [31:0] rd, input logic [31:0] sv);
        @(negedge clk);
        acc_kind  = 2'(k);
        acc_size  = 2'(s);
        acc_zext  = 1'(z);
        addr_lo   = 2'(o);
        mem_rdata = rd;
        st_src    = sv;
        #(CLK_P/4);
    endtask

    // Reference model built from lane arithmetic, not from shifts or slices.
    task automatic sweep_one(input int k, input int s, input int z, input int o,
                             input logic [31:0] rd, input logic [31:0] sv);
        longint unsigned scale, pick, e_ld, e_wd, e_mk;
        bit act, bad;
        string r_ld, r_wr, r_mis;
        scale = 1;
        for (int i = 0; i < o; i++) scale = scale * 256;
        act = (k == 1) || (k == 2);
        bad = (s == 3) || (s == 1 && (o % 2) == 1) || (s == 2 && o != 0);
        e_ld = 0; e_wd = 0; e_mk = 0;
        r_mis = act ? "R8" : "R10";
        if (!act)      begin r_ld = "R10"; r_wr = "R10"; end
        else if (bad)  begin r_ld = "R9";  r_wr = "R9";  end
        else if (k == 1) begin
            r_wr = "R11";
            if (s == 0) begin
                r_ld = "R2";
                pick = (longint'(rd) / scale) % 256;
                if (z == 0 && pick >= 128) pick = pick + 64'hFFFF_FF00;
                e_ld = pick;
            end else if (s == 1) begin
                r_ld = "R3";
                pick = (longint'(rd) / scale) % 65536;
                if (z == 0 && pick >= 32768) pick = pick + 64'hFFFF_0000;
                e_ld = pick;
            end else begin
                r_ld = "R4";
                e_ld = longint'(rd);
            end
        end else begin
            r_ld = "R11";
            if (s == 0) begin
                r_wr = "R5";
                e_wd = (longint'(sv) % 256) * scale;
                e_mk = scale == 1 ? 1 : (o == 1 ? 2 : (o == 2 ? 4 : 8));
            end else if (s == 1) begin
                r_wr = "R6";
                e_wd = (longint'(sv) % 65536) * scale;
                e_mk = (o == 0) ? 3 : 12;
            end else begin
                r_wr = "R7";
                e_wd = longint'(sv);
                e_mk = 15;
            end
        end
        apply(k, s, z, o, rd, sv);
        chk(r_ld,  "ld_value",   ld_value,           32'(e_ld));
        chk(r_wr,  "mem_wdata",  mem_wdata,          32'(e_wd));
        chk(r_wr,  "mem_wmask",  {28'h0, mem_wmask}, 32'(e_mk));
        chk(r_mis, "misaligned", {31'h0, misaligned}, {31'h0, (act && bad)});
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h80FF_7F01;
        pats[1] = 32'h7F80_017E;
        pats[2] = 32'hDEAD_BEEF;
        pats[3] = 32'h0000_0000;
        pats[4] = 32'hFFFF_FFFF;
        pats[5] = 32'h1280_8012;

        // R10: idle state right after start.
        apply(0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R10", "idle wmask", {28'h0, mem_wmask}, 32'h0);
        chk("R10", "idle misaligned", {31'h0, misaligned}, 32'h0);

        // R1: distinct byte values reveal lane order.
        for (int o = 0; o < 4; o++) begin
            apply(1, 0, 1, o, 32'h4433_2211, 32'h0);
            chk("R1", "lane order", ld_value, 32'(17 * (o + 1)));
        end

        // R2..R11: full sweep of kind, width, extension and offset.
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 4; s++)
                    for (int z = 0; z < 2; z++)
                        for (int o = 0; o < 4; o++)
                            sweep_one(k, s, z, o, pats[p], pats[(p + 2) % 6]);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule